// File: doc/BRIEF.md
# Serial Port Modem Control with Diagnostic Loopback

This block holds the modem control register of a serial port and does the combinational routing that the register selects. It drives the two active-low handshake outputs, "data terminal ready" and "request to send". It keeps one general-purpose flag that only the CPU can see. It decides whether the port's interrupt line is driven or left floating.

One register bit puts the port into self-test. In that mode the transmit line idles at the marking level and the external receive pin is ignored. The transmit shifter output feeds the receive shifter input directly. The four external modem status inputs are replaced by the register's own control bits, so software can send characters and toggle handshake lines without any cable attached.

The interrupt pin is modelled as a data output plus an output enable. A pad cell elsewhere turns these into a three-state pin. Detecting changes on the modem status lines belongs to a neighbouring block, which reads `status_o`.

Top module: `modem_ctl_loop`

## Requirements
- R1: After reset the stored control bits are 0. This means `dtr_n_o` and `rts_n_o` are 1, `irq_oe_o` is 0, and loopback is off (`txd_o` follows `tx_shift_i`).
- R2: A write with `bus_wr` high and `bus_addr` equal to 4 stores `bus_wdata[4:0]` at the clock edge. The stored value is presented on `rd_data` while `bus_addr` is 4. Bits 7:5 always read 0. `rd_data` is 0 at any other address. A write to any other address leaves the register unchanged.
- R3: Outside loopback, `dtr_n_o` is the inverse of control bit 0 and `rts_n_o` is the inverse of control bit 1.
- R4: Control bit 2 reaches no output pin. It only reads back on `rd_data[2]`, and in loopback it appears as the ring indicator status.
- R5: When control bit 3 is 1 and loopback is off, `irq_oe_o` is 1 and `irq_o` equals `irq_req_i`. Otherwise `irq_oe_o` is 0 (high impedance) and `irq_o` is 0.
- R6: When control bit 4 is 1, `txd_o` is 1 and `rx_shift_o` equals `tx_shift_i`, whatever `rxd_i` is. When control bit 4 is 0, `txd_o` equals `tx_shift_i` and `rx_shift_o` equals `rxd_i`.
- R7: `status_o` is active-high with bit 0 CTS, bit 1 DSR, bit 2 RI and bit 3 DCD. Outside loopback it is the inverse of `cts_n_i`, `dsr_n_i`, `ri_n_i` and `dcd_n_i`. In loopback the external inputs are ignored, and CTS, DSR, RI and DCD take control bits 1, 0, 2 and 3 respectively.
- R8: In loopback `dtr_n_o` and `rts_n_o` are both 1, whatever the control bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the control register |
| dtr_n_o | output | 1 | Data terminal ready, active low |
| rts_n_o | output | 1 | Request to send, active low |
| irq_req_i | input | 1 | Interrupt request from the port core |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe_o | output | 1 | Interrupt pin output enable |
| tx_shift_i | input | 1 | Transmit shifter serial output |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |
| rx_shift_o | output | 1 | Receive shifter serial input |
| cts_n_i | input | 1 | Clear to send pin, active low |
| dsr_n_i | input | 1 | Data set ready pin, active low |
| ri_n_i | input | 1 | Ring indicator pin, active low |
| dcd_n_i | input | 1 | Carrier detect pin, active low |
| status_o | output | 4 | Active-high modem status {DCD,RI,DSR,CTS} |

## Verification
The only storage is the control register, so every result of a register write is due one clock edge after the write is sampled. Pin inputs reach their outputs in the same cycle, with no clock in between. The bench drives each write on a falling edge, releases it on the next falling edge, and checks the register-dependent outputs there, half a period after the updating edge. With the register held, it sweeps every combination of modem pins, serial data and interrupt request and checks the outputs a short delay later, without advancing the clock. All 256 write values are covered, including those with bits 7:5 set.

// File: rtl/modem_ctl_loop.sv
module modem_ctl_loop #(
  parameter int ADDR_W = 3,
  parameter int OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        rd_data,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  input  logic              irq_req_i,
  output logic              irq_o,
  output logic              irq_oe_o,
  input  logic              tx_shift_i,
  output logic              txd_o,
  input  logic              rxd_i,
  output logic              rx_shift_o,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  output logic [3:0]        status_o
);

  localparam int CTL_W = 5;
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(OFFSET);

  logic [CTL_W-1:0] ctl_q;
  logic             hit, loop;
  logic             dtr, rts, gp, ien;

  assign hit  = (bus_addr == SEL);
  assign dtr  = ctl_q[0];
  assign rts  = ctl_q[1];
  assign gp   = ctl_q[2];
  assign ien  = ctl_q[3];
  assign loop = ctl_q[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            ctl_q <= '0;
    else if (bus_wr && hit) ctl_q <= bus_wdata[CTL_W-1:0];

  assign rd_data = hit ? {{(8-CTL_W){1'b0}}, ctl_q} : 8'h00;

  assign dtr_n_o = loop | ~dtr;
  assign rts_n_o = loop | ~rts;

  assign irq_oe_o = ien & ~loop;
  assign irq_o    = irq_oe_o & irq_req_i;

  assign txd_o      = loop | tx_shift_i;
  assign rx_shift_o = loop ? tx_shift_i : rxd_i;

  assign status_o = loop ? {ien, gp, dtr, rts}
                         : ~{dcd_n_i, ri_n_i, dsr_n_i, cts_n_i};

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit) |=> $stable(ctl_q));

  // R3
  hs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && !bus_wdata[4]) |=>
      (dtr_n_o == !$past(bus_wdata[0])) && (rts_n_o == !$past(bus_wdata[1])));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_oe_o |-> !irq_o);

  // R6
  loop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4]) |=> txd_o && (rx_shift_o == tx_shift_i));

  // R7
  loop_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4]) |=>
      status_o == {$past(bus_wdata[3]), $past(bus_wdata[2]),
                   $past(bus_wdata[0]), $past(bus_wdata[1])});

  // R8
  loop_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit && bus_wdata[4]) |=> dtr_n_o && rts_n_o);

endmodule

// File: tb/modem_ctl_loop_tb_top.sv
`timescale 1ns/1ps
module modem_ctl_loop_tb_top;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 3'd4;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0, rd_data;
  logic dtr_n_o, rts_n_o, irq_req_i = 0, irq_o, irq_oe_o;
  logic tx_shift_i = 1, txd_o, rxd_i = 1, rx_shift_o;
  logic cts_n_i = 1, dsr_n_i = 1, ri_n_i = 1, dcd_n_i = 1;
  logic [3:0] status_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  modem_ctl_loop dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 3'd4;
  endtask

  task automatic check_all(input logic [7:0] v);
    logic lp;
    logic [3:0] exp_st;
    lp = v[4];
    chk("R2 readback", rd_data, {3'b000, v[4:0]});
    chk("R3/R8 dtr_n", {7'd0, dtr_n_o}, {7'd0, lp | ~v[0]});
    chk("R3/R8 rts_n", {7'd0, rts_n_o}, {7'd0, lp | ~v[1]});
    for (int p = 0; p < 64; p++) begin
      {dcd_n_i, ri_n_i, dsr_n_i, cts_n_i, rxd_i, tx_shift_i} = p[5:0];
      for (int q = 0; q < 2; q++) begin
        irq_req_i = q[0];
        #1;
        exp_st = lp ? {v[3], v[2], v[0], v[1]} : ~p[5:2];
        chk("R7 status", {4'd0, status_o}, {4'd0, exp_st});
        chk("R6 txd", {7'd0, txd_o}, {7'd0, lp | p[0]});
        chk("R6 rx_shift", {7'd0, rx_shift_o}, {7'd0, lp ? p[0] : p[1]});
        chk("R5 irq_oe", {7'd0, irq_oe_o}, {7'd0, v[3] & ~lp});
        chk("R5 irq", {7'd0, irq_o}, {7'd0, v[3] & ~lp & q[0]});
      end
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 reg", rd_data, 8'h00);
    chk("R1 dtr_n/rts_n", {6'd0, dtr_n_o, rts_n_o}, 8'h03);
    chk("R1 irq_oe", {7'd0, irq_oe_o}, 8'h00);
    tx_shift_i = 0; #1;
    chk("R1 txd follows", {7'd0, txd_o}, 8'h00);
    rst_n = 1;
    check_all(8'h00);
    // R2 R3 R4 R5 R6 R7 R8 sweep over every written value
    for (int v = 0; v < 256; v++) begin
      wr(3'd4, v[7:0]);
      check_all(v[7:0]);
    end
    // R2 other offsets ignored, read 0
    wr(3'd4, 8'h00);
    wr(3'd3, 8'hFF);
    chk("R2 other offset write ignored", rd_data, 8'h00);
    chk("R2 dtr_n unchanged", {7'd0, dtr_n_o}, 8'h01);
    wr(3'd4, 8'h0F);
    bus_addr = 3'd5; #1;
    chk("R2 other offset reads 0", rd_data, 8'h00);
    bus_addr = 3'd4; #1;
    // R4 general bit only on readback
    chk("R4 gp readback", rd_data & 8'h04, 8'h04);
    // R1 reset mid-run clears register
    @(negedge clk); rst_n = 0; #1;
    chk("R1 reset clears", rd_data, 8'h00);
    chk("R1 irq_oe after reset", {7'd0, irq_oe_o}, 8'h00);
    @(negedge clk); rst_n = 1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule